// File: doc/BRIEF.md
# Dataway Command Handshake and LAM Logic

This block sits between an asynchronous crate dataway and a local CPU. Every dataway strobe (general command, read qualifier, S2 phase, command match, LAM test and module reset) is brought into the CPU clock through a flop synchronizer. A new command is accepted only when no earlier command is still waiting for the CPU. An accepted command answers Q (when it can) and raises an interrupt request at the trailing edge of S2. A command that overlaps a pending one is refused without Q and changes nothing.

Read data is prepared one command ahead: during its service routine the CPU latches a word for the next read and marks it ready. A read that finds ready data and a positive command match consumes the word and answers with Q, read enable and read valid. A read that finds no data, or data prepared for a different command, answers without Q. In the mismatch case the stale word is dropped. Either way the command still interrupts the CPU, so the CPU can fetch the proper word for the retry.

The same block keeps the LAM request. It holds sticky source bits, a mask that resets to all ones, a global enable, and two dataway operations answered purely in hardware: a LAM test whose Q reflects the LAM, and a module reset that always answers Q.

Top module: `dwhs_top`

## Requirements
- R1: A rising general command while nothing is pending is accepted: `cmd_pending` goes high. For a write (read qualifier low), `q_resp` rises and stays high until the general command falls.
- R2: A general command arriving while a command is pending is refused. `q_resp` and `rd_en` stay low, `cmd_pending` stays high and `data_rdy` is left unchanged.
- R3: `irq` stays low after acceptance until the S2 strobe falls, and is then set.
- R4: A one-cycle `cpu_clr` pulse clears both `cmd_pending` and `irq`.
- R5: An accepted read with `data_rdy` high and the match input high drives `q_resp` and `rd_en` high while the general command is high. It sets `rd_valid`, which holds until the next accepted command, and it clears `data_rdy`.
- R6: An accepted read with `data_rdy` low answers with `q_resp`, `rd_en` and `rd_valid` all low. The command is still pending and still interrupts at S2.
- R7: An accepted read with `data_rdy` high but the match input low clears `data_rdy` and answers without `q_resp`, `rd_en` or `rd_valid`.
- R8: A `cpu_latch` pulse sets `data_rdy`.
- R9: `lam_mask` resets to 0xFFFF and is loaded whole by `cpu_mask_we`. `lam` is high when the LAM is enabled and some source bit is set whose mask bit (same position) is set. Source bit 0 is the out-of-tolerance average, and bit 1 is fifteen or more bad pumps.
- R10: Source bits are set by one-cycle pulses on `lam_ev` and hold until a `cpu_src_rd` pulse clears them. A pulse on `lam_ev` in the same cycle as `cpu_src_rd` wins.
- R11: While the LAM test strobe is high, `q_resp` equals `lam`. The test raises no interrupt and leaves `cmd_pending` unchanged.
- R12: The module reset strobe gives `q_resp` high while the strobe is high, and exactly one `mod_rst_req` pulse per strobe. It raises no interrupt.
- R13: The LAM enable is high out of reset, is cleared by `cpu_lam_dis` and is set again by `cpu_lam_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dw_gcmd | input | 1 | Dataway general command strobe (asynchronous) |
| dw_rcmd | input | 1 | Read-command qualifier, high for a read (asynchronous) |
| dw_s2 | input | 1 | Dataway S2 phase strobe (asynchronous) |
| dw_match | input | 1 | Command-match: latched data belongs to this read (asynchronous) |
| dw_ltest | input | 1 | LAM test strobe (asynchronous) |
| dw_mrst | input | 1 | Module reset strobe (asynchronous) |
| cpu_clr | input | 1 | CPU write-data-enable strobe, clears pending and interrupt |
| cpu_latch | input | 1 | CPU has latched the word for the next read |
| cpu_src_rd | input | 1 | CPU read of the LAM source, clears it |
| cpu_mask_we | input | 1 | LAM mask write enable |
| cpu_mask_wdata | input | MASK_W | LAM mask write data |
| cpu_lam_en | input | 1 | Enable LAM |
| cpu_lam_dis | input | 1 | Disable LAM |
| lam_ev | input | SRC_W | LAM source set pulses |
| q_resp | output | 1 | Q response to the dataway |
| rd_en | output | 1 | Read data enable onto the dataway |
| rd_valid | output | 1 | Last accepted read delivered valid data |
| cmd_pending | output | 1 | A command waits for CPU service |
| irq | output | 1 | Interrupt request to the CPU |
| data_rdy | output | 1 | Prefetched read word is ready |
| lam | output | 1 | LAM request |
| lam_src | output | SRC_W | LAM source bits |
| lam_mask | output | MASK_W | LAM mask register |
| mod_rst_req | output | 1 | One-cycle module reset request |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 16-bit mask and two LAM sources. The small source width lets the bench sweep all 32 combinations of source bits, low mask bits and enable. The command side is swept over all 16 combinations of prior pending state, read or write, data ready and match. Each command strobe edge is placed at a varying offset inside the clock period, so acceptance is exercised across synchronizer phases rather than only at one alignment.

// File: rtl/dwhs_pkg.sv
// Shared types for the dataway command handshake.
// Assumes: dataway strobes are level signals held for several CPU clocks.
package dwhs_pkg;
    // Bundle of asynchronous dataway strobes carried through one synchronizer
    typedef struct packed {
        logic gcmd;
        logic rcmd;
        logic s2;
        logic match;
        logic ltest;
        logic mrst;
    } dw_sig_t;

    localparam int DW_BITS = $bits(dw_sig_t);
endpackage

// File: rtl/dwhs_sync.sv
// Multi-bit flop synchronizer, one chain per bit.
// Assumes: each bit is independent and held longer than STAGES clocks.
module dwhs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the asynchronous inputs through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dwhs_cmd_ctrl.sv
// Command interlock and read-data control.
// Accepts a general command only when none is pending, raises the CPU
// interrupt at the trailing edge of S2, and answers reads from a word
// that the CPU prefetched, dropping it when the command does not match.
// Assumes: all dataway inputs are already synchronized to clk.
module dwhs_cmd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic gcmd,
    input  logic rcmd,
    input  logic s2,
    input  logic match,
    input  logic cpu_clr,
    input  logic cpu_latch,
    output logic q_cmd,
    output logic rd_en,
    output logic rd_valid,
    output logic pending,
    output logic irq,
    output logic data_rdy
);
    logic gcmd_d, s2_d, armed;
    logic g_rise, g_fall, s2_fall, accept, hit;

    assign g_rise  = gcmd & ~gcmd_d;
    assign g_fall  = ~gcmd & gcmd_d;
    assign s2_fall = ~s2 & s2_d;
    assign accept  = g_rise & ~pending;
    assign hit     = accept & rcmd & data_rdy & match;

    // Edge history for the synchronized strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcmd_d <= 1'b0;
            s2_d   <= 1'b0;
        end else begin
            gcmd_d <= gcmd;
            s2_d   <= s2;
        end
    end

    // Q and read enable: decided at acceptance, dropped when gcmd falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cmd <= 1'b0;
            rd_en <= 1'b0;
        end else if (accept) begin
            q_cmd <= ~rcmd | (data_rdy & match);
            rd_en <= hit;
        end else if (g_fall) begin
            q_cmd <= 1'b0;
            rd_en <= 1'b0;
        end
    end

    // Read-valid flag: result of the latest accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_valid <= 1'b0;
        else if (accept) rd_valid <= hit;
    end

    // Pending interlock: first flop of the tandem pair
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= accept | (pending & ~cpu_clr);
    end

    // Arm the interrupt flop between acceptance and the S2 trailing edge
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed <= 1'b0;
        else if (cpu_clr)           armed <= 1'b0;
        else if (accept)            armed <= 1'b1;
        else if (s2_fall)           armed <= 1'b0;
    end

    // Interrupt request: second flop, set at S2 trailing edge, CPU clears
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq <= 1'b0;
        else if (cpu_clr)           irq <= 1'b0;
        else if (s2_fall && armed)  irq <= 1'b1;
    end

    // Prefetched word status: CPU sets, any accepted read consumes
    always_ff @(posedge clk) begin
        if (!rst_n) data_rdy <= 1'b0;
        else        data_rdy <= cpu_latch | (data_rdy & ~(accept & rcmd));
    end
endmodule

// File: rtl/dwhs_lam.sv
// LAM source, mask and enable, plus the hardware-only LAM test and
// module reset responses, which never involve the CPU.
// Assumes: ltest and mrst are synchronized; CPU strobes are single cycles.
module dwhs_lam #(
    parameter int MASK_W = 16,
    parameter int SRC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  ev,
    input  logic              src_rd,
    input  logic              mask_we,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              ltest,
    input  logic              mrst,
    output logic [SRC_W-1:0]  src,
    output logic [MASK_W-1:0] mask,
    output logic              lam,
    output logic              q_hw,
    output logic              mrst_req
);
    logic enable, mrst_d;

    // Sticky source bits; a new event beats the read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) src <= '0;
        else        src <= ev | (src & {SRC_W{~src_rd}});
    end

    // Mask register, all ones out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= mask_wdata;
    end

    // Global LAM enable
    always_ff @(posedge clk) begin
        if (!rst_n)      enable <= 1'b1;
        else if (en_clr) enable <= 1'b0;
        else if (en_set) enable <= 1'b1;
    end

    assign lam = enable & (|(src & mask[SRC_W-1:0]));

    // Hardware answers: LAM test reflects LAM, module reset always answers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hw     <= 1'b0;
            mrst_d   <= 1'b0;
            mrst_req <= 1'b0;
        end else begin
            q_hw     <= (ltest & lam) | mrst;
            mrst_d   <= mrst;
            mrst_req <= mrst & ~mrst_d;
        end
    end
endmodule

// File: rtl/dwhs_top.sv
// Dataway command handshake top: synchronizes the dataway strobes,
// then feeds the command interlock and the LAM logic.
// Assumes: command and hardware strobes never overlap on the dataway.
module dwhs_top #(
    parameter int SYNC_STAGES = 2,
    parameter int MASK_W      = 16,
    parameter int SRC_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dw_gcmd,
    input  logic              dw_rcmd,
    input  logic              dw_s2,
    input  logic              dw_match,
    input  logic              dw_ltest,
    input  logic              dw_mrst,
    input  logic              cpu_clr,
    input  logic              cpu_latch,
    input  logic              cpu_src_rd,
    input  logic              cpu_mask_we,
    input  logic [MASK_W-1:0] cpu_mask_wdata,
    input  logic              cpu_lam_en,
    input  logic              cpu_lam_dis,
    input  logic [SRC_W-1:0]  lam_ev,
    output logic              q_resp,
    output logic              rd_en,
    output logic              rd_valid,
    output logic              cmd_pending,
    output logic              irq,
    output logic              data_rdy,
    output logic              lam,
    output logic [SRC_W-1:0]  lam_src,
    output logic [MASK_W-1:0] lam_mask,
    output logic              mod_rst_req
);
    import dwhs_pkg::*;

    dw_sig_t raw, syn;
    logic    q_cmd, q_hw;

    assign raw = '{gcmd: dw_gcmd, rcmd: dw_rcmd, s2: dw_s2,
                   match: dw_match, ltest: dw_ltest, mrst: dw_mrst};

    dwhs_sync #(.WIDTH(DW_BITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    dwhs_cmd_ctrl u_cmd (
        .clk(clk), .rst_n(rst_n),
        .gcmd(syn.gcmd), .rcmd(syn.rcmd), .s2(syn.s2), .match(syn.match),
        .cpu_clr(cpu_clr), .cpu_latch(cpu_latch),
        .q_cmd(q_cmd), .rd_en(rd_en), .rd_valid(rd_valid),
        .pending(cmd_pending), .irq(irq), .data_rdy(data_rdy)
    );

    dwhs_lam #(.MASK_W(MASK_W), .SRC_W(SRC_W)) u_lam (
        .clk(clk), .rst_n(rst_n),
        .ev(lam_ev), .src_rd(cpu_src_rd),
        .mask_we(cpu_mask_we), .mask_wdata(cpu_mask_wdata),
        .en_set(cpu_lam_en), .en_clr(cpu_lam_dis),
        .ltest(syn.ltest), .mrst(syn.mrst),
        .src(lam_src), .mask(lam_mask), .lam(lam),
        .q_hw(q_hw), .mrst_req(mod_rst_req)
    );

    assign q_resp = q_cmd | q_hw;
endmodule

// File: rtl/dwhs_checker.sv
// Protocol checks for dwhs_top, attached by bind.
module dwhs_checker #(
    parameter int SRC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_clr,
    input logic             cpu_src_rd,
    input logic [SRC_W-1:0] lam_ev,
    input logic             q_resp,
    input logic             rd_en,
    input logic             rd_valid,
    input logic             data_rdy,
    input logic             irq,
    input logic             cmd_pending,
    input logic [SRC_W-1:0] lam_src,
    input logic             mod_rst_req
);
    assert_irq_only_when_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmd_pending);

    assert_clr_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clr |=> !irq);

    assert_clr_drops_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clr && cmd_pending) |=> !cmd_pending);

    assert_rden_with_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> q_resp);

    assert_valid_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(data_rdy));

    assert_src_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_src_rd && lam_ev == '0) |=> (lam_src == '0));

    assert_reset_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_req |=> !mod_rst_req);

    assert_reset_req_answers_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_req |-> q_resp);
endmodule

bind dwhs_top dwhs_checker #(.SRC_W(SRC_W)) u_chk (.*);

// File: tb/tb_dwhs_top.sv
`timescale 1ns/1ps
module tb_dwhs_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dw_gcmd = 0, dw_rcmd = 0, dw_s2 = 0, dw_match = 0, dw_ltest = 0, dw_mrst = 0;
    logic        cpu_clr = 0, cpu_latch = 0, cpu_src_rd = 0, cpu_mask_we = 0;
    logic [15:0] cpu_mask_wdata = '0;
    logic        cpu_lam_en = 0, cpu_lam_dis = 0;
    logic [1:0]  lam_ev = '0;
    logic        q_resp, rd_en, rd_valid, cmd_pending, irq, data_rdy, lam, mod_rst_req;
    logic [1:0]  lam_src;
    logic [15:0] lam_mask;

    int n_chk = 0, n_fail = 0, n_rstreq = 0;
    bit done = 0;
    int unsigned lcg = 32'h1234_5677;

    always #10 clk = ~clk;

    dwhs_top dut (.*);

    // Count module reset request cycles seen at the port
    always @(posedge clk) if (rst_n && mod_rst_req) n_rstreq++;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Step to a varied phase inside the clock period before an async edge
    task automatic phase();
        @(posedge clk);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        #(1 + (lcg >> 16) % 18);
    endtask

    task automatic cpu_pulse(int sel);
        @(negedge clk);
        case (sel)
            0: cpu_clr = 1;  1: cpu_latch = 1;  2: cpu_src_rd = 1;
            3: cpu_lam_en = 1; 4: cpu_lam_dis = 1; default: cpu_mask_we = 1;
        endcase
        @(negedge clk);
        {cpu_clr, cpu_latch, cpu_src_rd, cpu_lam_en, cpu_lam_dis, cpu_mask_we} = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {dw_gcmd, dw_rcmd, dw_s2, dw_match, dw_ltest, dw_mrst} = '0;
        lam_ev = '0;
        settle(3);
        rst_n = 1;
        settle(1);
    endtask

    task automatic plain_write();
        dw_rcmd = 0;
        phase(); dw_gcmd = 1; settle(6);
        phase(); dw_s2 = 1; settle(6);
        phase(); dw_s2 = 0; settle(6);
        phase(); dw_gcmd = 0; settle(6);
    endtask

    initial begin
        do_reset();
        chk("R1 reset pending", cmd_pending, 0);
        chk("R3 reset irq", irq, 0);
        chk("R9 reset mask", lam_mask, 16'hFFFF);

        // Command side: every combination of pending, read, ready, match
        for (int c = 0; c < 16; c++) begin
            bit pend, rd, rdy, m, acc, hit, expq;
            string tag;
            pend = c[3]; rd = c[2]; rdy = c[1]; m = c[0];
            acc  = !pend;
            hit  = acc && rd && rdy && m;
            expq = acc && (!rd || (rdy && m));
            tag  = pend ? "R2" : (!rd ? "R1" : (!rdy ? "R6" : (!m ? "R7" : "R5")));
            do_reset();
            if (pend) plain_write();
            if (rdy) begin
                cpu_pulse(1); settle(1);
                chk("R8 latch sets ready", data_rdy, 1);
            end
            dw_rcmd = rd; dw_match = m;
            phase(); dw_gcmd = 1; settle(6);
            chk({tag, " q during command"}, q_resp, expq);
            chk({tag, " rd_en"}, rd_en, hit);
            chk({tag, " pending"}, cmd_pending, 1);
            chk({tag, " data_rdy after command"}, data_rdy, (acc && rd) ? 0 : rdy);
            chk("R3 no irq before S2 falls", irq, pend);
            phase(); dw_s2 = 1; settle(6);
            chk("R3 no irq while S2 high", irq, pend);
            phase(); dw_s2 = 0; settle(6);
            chk("R3 irq after S2 falls", irq, 1);
            phase(); dw_gcmd = 0; settle(6);
            chk({tag, " q after gcmd falls"}, q_resp, 0);
            chk({tag, " rd_valid"}, rd_valid, hit);
            cpu_pulse(0); settle(1);
            chk("R4 clear pending", cmd_pending, 0);
            chk("R4 clear irq", irq, 0);
        end

        // LAM side: all sources, low mask bits and enable states
        for (int c = 0; c < 32; c++) begin
            logic [1:0]  s, mk;
            logic [15:0] wd;
            bit en, expl;
            s = c[4:3]; mk = c[2:1]; en = c[0];
            wd = {14'h2B5A ^ 14'(c), mk};
            expl = en && ((s & mk) != 0);
            do_reset();
            chk("R9 mask after reset", lam_mask, 16'hFFFF);
            chk("R13 lam idle after reset", lam, 0);
            @(negedge clk) lam_ev = s;
            @(negedge clk) lam_ev = '0;
            cpu_mask_wdata = wd; cpu_pulse(5);
            if (!en) cpu_pulse(4);
            settle(1);
            chk("R9 mask written", lam_mask, wd);
            chk("R10 source held", lam_src, s);
            chk(en ? "R9 lam value" : "R13 lam disabled", lam, expl);
            phase(); dw_ltest = 1; settle(6);
            chk("R11 test q follows lam", q_resp, expl);
            chk("R11 test raises no irq", irq, 0);
            chk("R11 test leaves pending", cmd_pending, 0);
            phase(); dw_ltest = 0; settle(6);
            chk("R11 q after test", q_resp, 0);
            if (!en) begin
                cpu_pulse(3); settle(1);
                chk("R13 re-enabled lam", lam, (s & mk) != 0);
            end
            cpu_pulse(2); settle(1);
            chk("R10 read clears source", lam_src, 0);
            chk("R10 lam after clear", lam, 0);
        end

        // Event in the same cycle as the read-clear wins
        do_reset();
        @(negedge clk) begin lam_ev = 2'b10; cpu_src_rd = 1; end
        @(negedge clk) begin lam_ev = 2'b00; cpu_src_rd = 0; end
        chk("R10 set beats clear", lam_src, 2'b10);

        // Module reset strobe
        do_reset();
        n_rstreq = 0;
        phase(); dw_mrst = 1; settle(6);
        chk("R12 reset answers q", q_resp, 1);
        chk("R12 reset raises no irq", irq, 0);
        phase(); dw_mrst = 0; settle(6);
        chk("R12 single request pulse", n_rstreq, 1);
        chk("R12 q after reset strobe", q_resp, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule